// File: doc/BRIEF.md
# External Interrupt Request Pending Logic

This block sits between the external interrupt pins and a processor core. It conditions two maskable request pins and one non-maskable request pin, all active low. Each maskable pin has its own priority field and a mode bit that selects level or edge sensitivity. The block keeps the pending state of every source and compares the pending requests against the core's current mask level. It then presents the single winning request, as a source index and a level, to the core.

The core answers a presented request by fetching two vector words, and it reports each fetch on a strobe. The block records which source was taken at the first-word fetch. It holds that source on its request output until the second-word fetch completes the service, and only then clears the edge latch of that source. A software-interrupt decode that arrives together with a first-word fetch discards that fetch. In that case nothing is recorded, and the interrupted edge request stays pending so that it is taken again later. The mask level, the fetch strobes and the software-interrupt decode all come from the core.

Top module: `ext_irq_pending`

## Requirements
- R1: After reset, `req_valid` and `svc_busy` are 0, and no request appears while all pins stay high.
- R2: In edge mode (mode bit 1), a high-to-low transition on an enabled pin latches a request. The request stays pending after the pin returns high. It is visible at most 3 clock edges after the pin falls.
- R3: In level mode (mode bit 0), an enabled pin is pending exactly while it is held low. A completed service does not clear it, and releasing the pin removes it.
- R4: A priority field of 00 disables a pin, and fields 01, 10 and 11 give levels 0, 1 and 2. A disabled pin never requests. Its edge latch is held at 0, so a falling edge seen while disabled does not produce a request after the pin is re-enabled.
- R5: A level request whose pin is disabled before its first vector fetch is cancelled. If the pin is disabled after that fetch, the request is still presented with the same index until the second fetch.
- R6: A first-word fetch (`vec_fetch1`) while a request is presented sets `svc_busy`. A second-word fetch (`vec_fetch2`) clears `svc_busy` and clears the edge latch of the served source.
- R7: When `swi_decode` is high during a first-word fetch, the fetch is discarded. `svc_busy` stays 0 and the edge latch of the presented source stays set.
- R8: The non-maskable pin is edge sensitive. It is reported as index 2 with level 3, it cannot be masked, and it wins over every maskable request.
- R9: A maskable request is presented only if its level is greater than or equal to `mask_lvl`. A mask of 3 therefore blocks every maskable request.
- R10: Among maskable requests that pass the mask, the higher level wins. At equal level, pin 0 wins over pin 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_n | input | 2 | Maskable request pins, active low, asynchronous |
| nmi_pin_n | input | 1 | Non-maskable request pin, active low, asynchronous |
| pri_cfg | input | 4 | Priority field per pin, pin i at bits [2i+1:2i]; 00 means disabled |
| edge_mode | input | 2 | Mode bit per pin: 1 selects edge, 0 selects level |
| mask_lvl | input | 2 | Current interrupt mask level from the core |
| vec_fetch1 | input | 1 | Core fetches the first vector word |
| vec_fetch2 | input | 1 | Core fetches the second vector word |
| swi_decode | input | 1 | Software interrupt decoded; discards a concurrent first-word fetch |
| req_valid | output | 1 | A request is presented to the core |
| req_idx | output | 2 | Winning source: 0 and 1 for the pins, 2 for the non-maskable pin |
| req_lvl | output | 2 | Level of the winning source |
| svc_busy | output | 1 | Between an accepted first-word fetch and the second-word fetch |

## Verification
The hardest cases to reach are the ones where the same request meets a different fate depending on when it was disabled or preempted relative to the two fetch strobes. The bench reaches them by holding a level request low and changing its priority field either before or after a single `vec_fetch1` pulse. It drives `swi_decode` in the same cycle as a first-word fetch of an edge request, and then checks that the latch is still pending by reading `req_valid` and `req_idx` afterwards. A falling edge sent while the priority field is 00, followed by re-enabling the pin, confirms that the latch was held in reset.

// File: rtl/irq_pkg.sv
// Package: shared level type and priority-field decoding for the
// interrupt request pending logic.
package irq_pkg;
    localparam int LVL_W = 2;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t NMI_LVL = 2'd3;

    // Map a non-zero 2-bit priority field to a level (01->0 .. 11->2).
    function automatic lvl_t field_to_lvl(input logic [1:0] field);
        return lvl_t'(field - 2'd1);
    endfunction
endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Multi-stage synchronizer for a vector of asynchronous active-low pins.
// Assumes the idle pin level is high, so every stage resets to 1 and
// reset cannot produce a false falling edge.
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // Shift the pin samples through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage[k] <= '1;
        end else begin
            stage[0] <= d;
            for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_src_pend.sv
// Module: irq_src_pend
// Pending state for one request source. Detects a falling edge of the
// synchronized pin and keeps it in a latch in edge mode, or passes the
// low level through in level mode. Assumes the input is synchronized.
// A disabled source or a source in level mode holds its latch at 0.
module irq_src_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,     // synchronized pin, active low
    input  logic enable,
    input  logic edge_sel,  // 1 = edge, 0 = level
    input  logic svc_clr,   // second-word fetch served this source
    output logic pend,
    output logic edge_q
);
    logic prev_s;
    logic fall;

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_s <= 1'b1;
        else        prev_s <= pin_s;
    end

    assign fall = prev_s & ~pin_s;

    // Edge latch: held in reset when disabled, set on a fall, cleared on service.
    always_ff @(posedge clk) begin
        if (!rst_n)                edge_q <= 1'b0;
        else if (!enable)          edge_q <= 1'b0;
        else if (!edge_sel)        edge_q <= 1'b0;
        else if (fall)             edge_q <= 1'b1;
        else if (svc_clr)          edge_q <= 1'b0;
    end

    assign pend = enable & (edge_sel ? edge_q : ~pin_s);
endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter
// Picks the winning request. The non-maskable source wins outright.
// Otherwise the highest maskable level at or above the mask wins, and a
// tie goes to the lower pin index. Purely combinational.
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_PINS = 2,
    localparam int IDX_W   = $clog2(NUM_PINS + 1)
) (
    input  logic [NUM_PINS-1:0] pend,
    input  lvl_t                lvl [NUM_PINS],
    input  logic                nmi_pend,
    input  lvl_t                mask,
    output logic                win_valid,
    output logic [IDX_W-1:0]    win_idx,
    output lvl_t                win_lvl
);
    // Scan the pins in index order, keeping only a strictly higher level.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (pend[i] && (lvl[i] >= mask) && (!win_valid || (lvl[i] > win_lvl))) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_lvl   = lvl[i];
            end
        end
        if (nmi_pend) begin
            win_valid = 1'b1;
            win_idx   = IDX_W'(NUM_PINS);
            win_lvl   = NMI_LVL;
        end
    end
endmodule

// File: rtl/ext_irq_pending.sv
// Module: ext_irq_pending (top)
// Conditions the maskable and non-maskable request pins, arbitrates
// against the core mask level and tracks the two-word vector fetch.
// Assumes the core raises vec_fetch1 only while req_valid is high.
// While svc_busy is high the presented request is frozen until vec_fetch2.
// swi_decode with vec_fetch1 discards that fetch; swi_decode while busy
// abandons the service without clearing any latch.
module ext_irq_pending
    import irq_pkg::*;
#(
    parameter int NUM_PINS    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(NUM_PINS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   irq_pin_n,
    input  logic                  nmi_pin_n,
    input  logic [2*NUM_PINS-1:0] pri_cfg,
    input  logic [NUM_PINS-1:0]   edge_mode,
    input  logic [LVL_W-1:0]      mask_lvl,
    input  logic                  vec_fetch1,
    input  logic                  vec_fetch2,
    input  logic                  swi_decode,
    output logic                  req_valid,
    output logic [IDX_W-1:0]      req_idx,
    output logic [LVL_W-1:0]      req_lvl,
    output logic                  svc_busy
);
    logic [NUM_PINS:0]   pins_s;
    logic [NUM_PINS-1:0] pin_pend;
    logic [NUM_PINS-1:0] edge_q;
    lvl_t                pin_lvl [NUM_PINS];
    logic                nmi_pend;
    logic                nmi_edge_q;
    logic                win_valid;
    logic [IDX_W-1:0]    win_idx;
    lvl_t                win_lvl;
    logic [IDX_W-1:0]    svc_idx;
    lvl_t                svc_lvl;
    logic                svc_done;

    irq_sync #(.W(NUM_PINS + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({nmi_pin_n, irq_pin_n}),
        .q     (pins_s)
    );

    assign svc_done = svc_busy && vec_fetch2 && !swi_decode;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic en;
        assign en         = (pri_cfg[2*g +: 2] != 2'b00);
        assign pin_lvl[g] = field_to_lvl(pri_cfg[2*g +: 2]);

        irq_src_pend u_pend (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_s    (pins_s[g]),
            .enable   (en),
            .edge_sel (edge_mode[g]),
            .svc_clr  (svc_done && (svc_idx == IDX_W'(g))),
            .pend     (pin_pend[g]),
            .edge_q   (edge_q[g])
        );
    end

    irq_src_pend u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pins_s[NUM_PINS]),
        .enable   (1'b1),
        .edge_sel (1'b1),
        .svc_clr  (svc_done && (svc_idx == IDX_W'(NUM_PINS))),
        .pend     (nmi_pend),
        .edge_q   (nmi_edge_q)
    );

    irq_arbiter #(.NUM_PINS(NUM_PINS)) u_arb (
        .pend      (pin_pend),
        .lvl       (pin_lvl),
        .nmi_pend  (nmi_pend),
        .mask      (mask_lvl),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    // Service tracker: capture on an accepted first fetch, end on second fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_busy <= 1'b0;
            svc_idx  <= '0;
            svc_lvl  <= '0;
        end else if (svc_busy) begin
            if (vec_fetch2 || swi_decode) svc_busy <= 1'b0;
        end else if (vec_fetch1 && win_valid && !swi_decode) begin
            svc_busy <= 1'b1;
            svc_idx  <= win_idx;
            svc_lvl  <= win_lvl;
        end
    end

    // Present the frozen service source while busy, else the arbiter winner.
    always_comb begin
        if (svc_busy) begin
            req_valid = 1'b1;
            req_idx   = svc_idx;
            req_lvl   = svc_lvl;
        end else begin
            req_valid = win_valid;
            req_idx   = win_idx;
            req_lvl   = win_lvl;
        end
    end
endmodule

// File: rtl/irq_checker.sv
// Module: irq_checker
// Protocol and arbitration properties for ext_irq_pending, bound to
// every instance of the top module below.
module irq_checker #(
    parameter int NUM_PINS = 2,
    localparam int IDX_W   = $clog2(NUM_PINS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*NUM_PINS-1:0] pri_cfg,
    input  logic [1:0]            mask_lvl,
    input  logic                  vec_fetch1,
    input  logic                  vec_fetch2,
    input  logic                  swi_decode,
    input  logic                  req_valid,
    input  logic [IDX_W-1:0]      req_idx,
    input  logic [1:0]            req_lvl,
    input  logic                  svc_busy,
    input  logic                  nmi_edge_q,
    input  logic [NUM_PINS-1:0]   edge_q
);
    // R6
    busy_presents_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_busy |-> req_valid);

    // R6
    fetch2_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_busy && vec_fetch2) |=> !svc_busy);

    // R7
    swi_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc_busy && vec_fetch1 && swi_decode) |=> !svc_busy);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_busy && !vec_fetch2 && !swi_decode) |=> (req_valid && $stable(req_idx)));

    // R8
    nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_edge_q && !svc_busy) |-> (req_valid && req_idx == IDX_W'(NUM_PINS) && req_lvl == 2'd3));

    // R9
    mask_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !svc_busy && req_idx != IDX_W'(NUM_PINS)) |-> (req_lvl >= mask_lvl));

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_dis
        // R4
        disabled_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pri_cfg[2*g +: 2] == 2'b00) |=> !edge_q[g]);
    end
endmodule

bind ext_irq_pending irq_checker #(.NUM_PINS(NUM_PINS)) u_irq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pri_cfg    (pri_cfg),
    .mask_lvl   (mask_lvl),
    .vec_fetch1 (vec_fetch1),
    .vec_fetch2 (vec_fetch2),
    .swi_decode (swi_decode),
    .req_valid  (req_valid),
    .req_idx    (req_idx),
    .req_lvl    (req_lvl),
    .svc_busy   (svc_busy),
    .nmi_edge_q (nmi_edge_q),
    .edge_q     (edge_q)
);

// File: tb/tb_ext_irq_pending.sv
// Bench for ext_irq_pending: an arbitration vector table followed by
// directed tests of edge, level, disable, service and preemption cases.
module tb_ext_irq_pending;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] irq_pin_n;
    logic       nmi_pin_n;
    logic [3:0] pri_cfg;
    logic [1:0] edge_mode;
    logic [1:0] mask_lvl;
    logic       vec_fetch1, vec_fetch2, swi_decode;
    logic       req_valid;
    logic [1:0] req_idx;
    logic [1:0] req_lvl;
    logic       svc_busy;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_pending dut (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .nmi_pin_n(nmi_pin_n),
        .pri_cfg(pri_cfg), .edge_mode(edge_mode), .mask_lvl(mask_lvl),
        .vec_fetch1(vec_fetch1), .vec_fetch2(vec_fetch2), .swi_decode(swi_decode),
        .req_valid(req_valid), .req_idx(req_idx), .req_lvl(req_lvl), .svc_busy(svc_busy)
    );

    // Entry: {pri1, pri0, mask, exp_valid, exp_idx, exp_lvl}; both pins level, held low.
    localparam logic [10:0] VEC [9] = '{
        11'b01_01_00_1_00_00,
        11'b10_01_00_1_01_01,
        11'b10_11_00_1_00_10,
        11'b11_11_10_1_00_10,
        11'b10_01_01_1_01_01,
        11'b01_10_10_0_00_00,
        11'b11_11_11_0_00_00,
        11'b01_00_00_1_01_00,
        11'b00_00_00_0_00_00
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_f1(input bit with_swi);
        @(negedge clk); vec_fetch1 = 1'b1; swi_decode = with_swi;
        @(negedge clk); vec_fetch1 = 1'b0; swi_decode = 1'b0;
    endtask

    task automatic pulse_f2();
        @(negedge clk); vec_fetch2 = 1'b1;
        @(negedge clk); vec_fetch2 = 1'b0;
    endtask

    task automatic fall_pin(input int p);
        @(negedge clk);
        if (p == 2) nmi_pin_n = 1'b0; else irq_pin_n[p] = 1'b0;
        cyc(4);
        if (p == 2) nmi_pin_n = 1'b1; else irq_pin_n[p] = 1'b1;
        cyc(2);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_pin_n = 2'b11; nmi_pin_n = 1'b1;
        pri_cfg = 4'b0; edge_mode = 2'b00; mask_lvl = 2'd0;
        vec_fetch1 = 1'b0; vec_fetch2 = 1'b0; swi_decode = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        chk("R1", "req_valid", req_valid, 0);
        chk("R1", "svc_busy", svc_busy, 0);
        pri_cfg = 4'b1111; edge_mode = 2'b11;
        cyc(4);
        chk("R1", "idle req_valid", req_valid, 0);

        // Arbitration table, both pins level mode and low (R9, R10, R4).
        edge_mode = 2'b00; irq_pin_n = 2'b00;
        cyc(3);
        foreach (VEC[i]) begin
            pri_cfg  = VEC[i][10:7];
            mask_lvl = VEC[i][6:5];
            cyc(1);
            chk(VEC[i][4] ? "R10" : "R9", "req_valid", req_valid, VEC[i][4]);
            if (VEC[i][4]) begin
                chk("R10", "req_idx", req_idx, VEC[i][3:2]);
                chk("R10", "req_lvl", req_lvl, VEC[i][1:0]);
            end
        end
        irq_pin_n = 2'b11; mask_lvl = 2'd0;
        cyc(3);

        // R2 / R6: edge latch holds after release, service clears it.
        pri_cfg = 4'b0001; edge_mode = 2'b01;
        fall_pin(0);
        chk("R2", "req_valid", req_valid, 1);
        chk("R2", "req_idx", req_idx, 0);
        pulse_f1(1'b0);
        chk("R6", "svc_busy after f1", svc_busy, 1);
        pulse_f2();
        chk("R6", "svc_busy after f2", svc_busy, 0);
        chk("R6", "req_valid after f2", req_valid, 0);

        // R3: level request survives service, leaves on release.
        pri_cfg = 4'b0100; edge_mode = 2'b00; irq_pin_n = 2'b01;
        cyc(3);
        chk("R3", "req_valid low", req_valid, 1);
        chk("R3", "req_idx", req_idx, 1);
        pulse_f1(1'b0); pulse_f2();
        chk("R3", "req_valid after service", req_valid, 1);
        irq_pin_n = 2'b11;
        cyc(3);
        chk("R3", "req_valid released", req_valid, 0);

        // R4: falling edge while disabled leaves no latch.
        pri_cfg = 4'b0000; edge_mode = 2'b01;
        fall_pin(0);
        pri_cfg = 4'b0001;
        cyc(2);
        chk("R4", "req_valid re-enabled", req_valid, 0);

        // R5: level disabled before first fetch is cancelled.
        pri_cfg = 4'b0100; edge_mode = 2'b00; irq_pin_n = 2'b01;
        cyc(3);
        pri_cfg = 4'b0000;
        cyc(1);
        chk("R5", "cancelled req_valid", req_valid, 0);
        // R5: disabled after first fetch is still served.
        pri_cfg = 4'b0100;
        cyc(1);
        pulse_f1(1'b0);
        pri_cfg = 4'b0000;
        cyc(1);
        chk("R5", "held req_valid", req_valid, 1);
        chk("R5", "held req_idx", req_idx, 1);
        pulse_f2();
        chk("R5", "req_valid after f2", req_valid, 0);
        irq_pin_n = 2'b11;
        cyc(3);

        // R7: software interrupt discards first fetch, edge latch kept.
        pri_cfg = 4'b0001; edge_mode = 2'b01;
        fall_pin(0);
        pulse_f1(1'b1);
        chk("R7", "svc_busy", svc_busy, 0);
        chk("R7", "req_valid", req_valid, 1);
        chk("R7", "req_idx", req_idx, 0);
        pulse_f1(1'b0); pulse_f2();
        chk("R7", "cleared later", req_valid, 0);

        // R8: NMI beats a masked level request and ignores mask 3.
        pri_cfg = 4'b1100; edge_mode = 2'b00; irq_pin_n = 2'b01; mask_lvl = 2'd3;
        cyc(3);
        chk("R9", "masked req_valid", req_valid, 0);
        fall_pin(2);
        chk("R8", "req_idx", req_idx, 2);
        chk("R8", "req_lvl", req_lvl, 3);
        mask_lvl = 2'd0;
        cyc(1);
        chk("R8", "req_idx over lvl2", req_idx, 2);
        pulse_f1(1'b0); pulse_f2();
        chk("R8", "after service idx", req_idx, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule